// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds the time of day and the calendar date as packed BCD bytes: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A 32.768 kHz rate arrives as a one-cycle clock enable. A sub-second divider turns that rate into one advance per second. The advance then ripples through every field in a single clock cycle.

Each field is loaded through a simple byte write port. Loading the seconds byte also restarts the sub-second divider, so the next advance comes a full second after the load. The top bit of the seconds byte freezes the whole clock. The hours byte can count in a 24-hour format or in a 12-hour format with a PM flag. Month lengths and February of leap years are handled inside the block.

Top module: `rtc_calendar_core`

## Requirements
- R1: After a synchronous reset the fields read seconds 00, minutes 00, hours 00 (24-hour format), weekday 01, date 01, month 01 and year 00.
- R2: The seconds field advances once for every DIV asserted cycles of `tick_32k`. While bit 7 of the seconds byte is 1, neither the fields nor the divider advance. Bit 7 is kept across advances.
- R3: Writing field 0 (seconds) restarts the divider. The next advance needs DIV further enables. An advance that falls in the same cycle as that write is dropped.
- R4: Seconds (bits 6:0) and minutes count in BCD from 00 to 59. The step from 59 to 00 carries into the next field.
- R5: With hours bit 6 = 0 (24-hour format), bits 5:0 count in BCD from 00 to 23. The step from 23 to 00 starts a new day.
- R6: With hours bit 6 = 1 (12-hour format), bit 5 is PM (1 = PM) and bits 4:0 count in BCD from 01 to 12. Hour 11 steps to 12 and flips PM. Hour 12 steps to 01. A new day starts only on the step from 11 PM to 12 AM.
- R7: The weekday steps by one on each new day and goes from 07 back to 01.
- R8: The date goes back to 01 and the month advances after the last day of the month. That last day is 30 for months 04, 06, 09 and 11, 31 for the other months, and 28 or 29 for month 02.
- R9: February has 29 days when the BCD year value is divisible by 4. Year 00 counts as a leap year.
- R10: Month 12 steps to 01 and advances the year. Year 99 steps to 00.
- R11: The write port addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month and 6 year. A written byte is stored as given. When a write meets an advance in the same cycle, the written field takes the written byte, any carry into that field is lost, and the other fields still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | Enable at the 32.768 kHz rate |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field select for the write |
| wr_data | input | 8 | Byte to store |
| sec_o | output | 8 | Halt bit and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Format bit, PM or tens bit, BCD hour |
| wday_o | output | 8 | Weekday 1-7 |
| date_o | output | 8 | BCD day of month |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |

## Verification
A field write and a once-per-second advance can land in the same clock cycle. The bench provokes this by running the divider to one enable short of its wrap. It then raises the write strobe together with the final enable. For a seconds write, the stored byte must appear unchanged and the next advance must come only after a full DIV enables. For a minutes write made when the seconds are at 59, the seconds must roll to 00 while the minutes take the written byte and not the carry.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [2:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_WDAY  = 3'd3,
        FLD_DATE  = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6
    } field_e;

    typedef struct packed {
        logic       en;
        field_e     fld;
        logic [7:0] data;
    } wr_req_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic is_leap(input logic [7:0] yr);
        logic odd_tens;
        odd_tens = yr[4];
        if (!odd_tens)
            return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    endfunction

    function automatic logic [7:0] last_date(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/subsec_divider.sv
module subsec_divider #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic halt,
    input  logic clear,
    output logic sec_tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          running;

    assign running  = tick_en && !halt;
    assign sec_tick = running && !clear && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (running)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // R2: a halted divider keeps its count
    assert_halt_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (halt && !clear) |=> $stable(cnt_q));

    // R3: the cycle after a restart can never produce an advance (DIV >= 2)
    assert_clear_restart_R3: assert property (@(posedge clk) disable iff (rst)
        clear |=> !sec_tick);

endmodule

// File: rtl/time_of_day_chain.sv
module time_of_day_chain
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  wr_req_t    wr,
    output logic [7:0] sec_q,
    output logic [7:0] min_q,
    output logic [7:0] hour_q,
    output logic       day_carry
);
    logic       sec_wrap, min_wrap, min_step, hour_step;
    logic [7:0] sec_inc, min_inc, h12_inc, h24_inc;
    logic [7:0] hour_nx;
    logic       hour_day;

    assign sec_wrap = (sec_q[6:0] == 7'h59);
    assign min_wrap = (min_q[6:0] == 7'h59);
    assign sec_inc  = bcd_inc({1'b0, sec_q[6:0]});
    assign min_inc  = bcd_inc({1'b0, min_q[6:0]});
    assign h12_inc  = bcd_inc({3'b000, hour_q[4:0]});
    assign h24_inc  = bcd_inc({2'b00, hour_q[5:0]});
    assign min_step = adv && sec_wrap;
    assign hour_step = min_step && min_wrap;

    always_comb begin
        hour_nx  = hour_q;
        hour_day = 1'b0;
        if (hour_q[6]) begin
            if (hour_q[4:0] == 5'h12) begin
                hour_nx = {hour_q[7:5], 5'h01};
            end else if (hour_q[4:0] == 5'h11) begin
                hour_nx  = {hour_q[7:6], ~hour_q[5], 5'h12};
                hour_day = hour_q[5];
            end else begin
                hour_nx = {hour_q[7:5], h12_inc[4:0]};
            end
        end else begin
            if (hour_q[5:0] == 6'h23) begin
                hour_nx  = {hour_q[7:6], 6'h00};
                hour_day = 1'b1;
            end else begin
                hour_nx = {hour_q[7:6], h24_inc[5:0]};
            end
        end
    end

    assign day_carry = hour_step && hour_day;

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q  <= 8'h00;
            min_q  <= 8'h00;
            hour_q <= 8'h00;
        end else begin
            if (wr.en && wr.fld == FLD_SEC)
                sec_q <= wr.data;
            else if (adv)
                sec_q <= {sec_q[7], sec_wrap ? 7'h00 : sec_inc[6:0]};

            if (wr.en && wr.fld == FLD_MIN)
                min_q <= wr.data;
            else if (min_step)
                min_q <= {min_q[7], min_wrap ? 7'h00 : min_inc[6:0]};

            if (wr.en && wr.fld == FLD_HOUR)
                hour_q <= wr.data;
            else if (hour_step)
                hour_q <= hour_nx;
        end
    end

    // R4: seconds roll from 59 to 00
    assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (adv && sec_q[6:0] == 7'h59 && !wr.en) |=> (sec_q[6:0] == 7'h00));

    // R6: 11:59:59 PM steps to 12 AM
    assert_pm_to_am_R6: assert property (@(posedge clk) disable iff (rst)
        (adv && hour_q == 8'h71 && min_q == 8'h59 && sec_q[6:0] == 7'h59 && !wr.en)
        |=> (hour_q == 8'h52));

    // R5: 23:59:59 in 24-hour format starts a new day
    assert_midnight_carry_R5: assert property (@(posedge clk) disable iff (rst)
        (adv && hour_q == 8'h23 && min_q == 8'h59 && sec_q[6:0] == 7'h59) |-> day_carry);

endmodule

// File: rtl/calendar_chain.sv
module calendar_chain
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       new_day,
    input  wr_req_t    wr,
    output logic [7:0] wday_q,
    output logic [7:0] date_q,
    output logic [7:0] month_q,
    output logic [7:0] year_q
);
    logic [7:0] month_end;
    logic       date_wrap, month_step, year_step;

    assign month_end  = last_date(month_q, is_leap(year_q));
    assign date_wrap  = (date_q == month_end);
    assign month_step = new_day && date_wrap;
    assign year_step  = month_step && (month_q == 8'h12);

    always_ff @(posedge clk) begin
        if (rst) begin
            wday_q  <= 8'h01;
            date_q  <= 8'h01;
            month_q <= 8'h01;
            year_q  <= 8'h00;
        end else begin
            if (wr.en && wr.fld == FLD_WDAY)
                wday_q <= wr.data;
            else if (new_day)
                wday_q <= (wday_q == 8'h07) ? 8'h01 : bcd_inc(wday_q);

            if (wr.en && wr.fld == FLD_DATE)
                date_q <= wr.data;
            else if (new_day)
                date_q <= date_wrap ? 8'h01 : bcd_inc(date_q);

            if (wr.en && wr.fld == FLD_MONTH)
                month_q <= wr.data;
            else if (month_step)
                month_q <= (month_q == 8'h12) ? 8'h01 : bcd_inc(month_q);

            if (wr.en && wr.fld == FLD_YEAR)
                year_q <= wr.data;
            else if (year_step)
                year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
        end
    end

    // R7: weekday 7 wraps to 1
    assert_wday_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (new_day && wday_q == 8'h07 && !wr.en) |=> (wday_q == 8'h01));

    // R9: leap February reaches its 29th day
    assert_leap_feb_R9: assert property (@(posedge clk) disable iff (rst)
        (new_day && month_q == 8'h02 && date_q == 8'h28 && year_q == 8'h24 && !wr.en)
        |=> (date_q == 8'h29));

    // R10: end of year 99 wraps to year 00
    assert_year_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (new_day && month_q == 8'h12 && date_q == 8'h31 && year_q == 8'h99 && !wr.en)
        |=> (year_q == 8'h00 && month_q == 8'h01));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_pkg::*;
#(
    parameter int DIV = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_32k,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o
);
    wr_req_t wr;
    logic    sec_tick, new_day, sec_load;

    assign wr.en    = wr_en;
    assign wr.fld   = field_e'(wr_addr);
    assign wr.data  = wr_data;
    assign sec_load = wr_en && (wr_addr == 3'd0);

    subsec_divider #(.DIV(DIV)) u_div (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_32k),
        .halt     (sec_o[7]),
        .clear    (sec_load),
        .sec_tick (sec_tick)
    );

    time_of_day_chain u_tod (
        .clk       (clk),
        .rst       (rst),
        .adv       (sec_tick),
        .wr        (wr),
        .sec_q     (sec_o),
        .min_q     (min_o),
        .hour_q    (hour_o),
        .day_carry (new_day)
    );

    calendar_chain u_cal (
        .clk     (clk),
        .rst     (rst),
        .new_day (new_day),
        .wr      (wr),
        .wday_q  (wday_o),
        .date_q  (date_o),
        .month_q (month_o),
        .year_q  (year_o)
    );

    // R2: with the halt bit set and no write, the seconds byte holds
    assert_halt_freeze_R2: assert property (@(posedge clk) disable iff (rst)
        (sec_o[7] && !wr_en) |=> $stable(sec_o));

    // R11: a written byte is stored as given
    assert_write_store_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd4) |=> (date_o == $past(wr_data)));

endmodule

// File: tb/tb_rtc_calendar_core.sv
`timescale 1ns/1ps
module tb_rtc_calendar_core;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_32k = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    // model state, plain integers
    int m_halt, m_sec, m_min, m_hr, m_pm, m_12, m_wday, m_date, m_mon, m_yr;

    always #2.5 clk = ~clk;

    rtc_calendar_core #(.DIV(DIV)) dut (
        .clk(clk), .rst(rst), .tick_32k(tick_32k),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] sec_byte();
        return bcd(m_sec) | (m_halt != 0 ? 8'h80 : 8'h00);
    endfunction

    function automatic logic [7:0] hour_byte();
        if (m_12 != 0) return 8'h40 | (m_pm != 0 ? 8'h20 : 8'h00) | bcd(m_hr);
        return bcd(m_hr);
    endfunction

    task automatic model_reset();
        m_halt = 0; m_sec = 0; m_min = 0; m_hr = 0; m_pm = 0; m_12 = 0;
        m_wday = 1; m_date = 1; m_mon = 1; m_yr = 0;
    endtask

    task automatic model_day();
        m_wday = (m_wday == 7) ? 1 : m_wday + 1;
        m_date++;
        if (m_date > mdays(m_mon, m_yr)) begin
            m_date = 1;
            m_mon++;
            if (m_mon == 13) begin
                m_mon = 1;
                m_yr = (m_yr + 1) % 100;
            end
        end
    endtask

    task automatic model_hour();
        if (m_12 != 0) begin
            if (m_hr == 11) begin
                m_hr = 12;
                if (m_pm != 0) model_day();
                m_pm = (m_pm != 0) ? 0 : 1;
            end else if (m_hr == 12) m_hr = 1;
            else m_hr++;
        end else begin
            m_hr++;
            if (m_hr == 24) begin
                m_hr = 0;
                model_day();
            end
        end
    endtask

    task automatic model_tick();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0;
            m_min++;
            if (m_min == 60) begin
                m_min = 0;
                model_hour();
            end
        end
    endtask

    task automatic check(input string tag);
        logic [55:0] got, exp;
        got = {sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o};
        exp = {sec_byte(), bcd(m_min), hour_byte(), bcd(m_wday), bcd(m_date), bcd(m_mon), bcd(m_yr)};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        tick_32k = 1'b0;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_32k = 1'b1;
        end
        @(negedge clk);
        tick_32k = 1'b0;
    endtask

    // divider taken to one short of its wrap, then write during the final enable
    task automatic wr_on_tick(input logic [2:0] a, input logic [7:0] d);
        for (int i = 0; i < DIV - 1; i++) begin
            @(negedge clk);
            tick_32k = 1'b1;
        end
        @(negedge clk);
        tick_32k = 1'b1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        tick_32k = 1'b0;
        wr_en = 1'b0;
    endtask

    // R11: all fields loaded through addresses 1..6, seconds (address 0) last
    task automatic load();
        wr(3'd1, bcd(m_min));
        wr(3'd2, hour_byte());
        wr(3'd3, bcd(m_wday));
        wr(3'd4, bcd(m_date));
        wr(3'd5, bcd(m_mon));
        wr(3'd6, bcd(m_yr));
        wr(3'd0, sec_byte());
    endtask

    task automatic step_and_check(input string tag);
        load();
        check({tag, " load R11"});
        run(DIV);
        model_tick();
        check(tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset");

        // R2: halted clock holds
        m_halt = 1; m_sec = 10;
        wr(3'd0, sec_byte());
        run(3 * DIV);
        check("R2 halt holds");
        m_halt = 0;
        wr(3'd0, sec_byte());
        run(DIV - 1);
        check("R3 no advance before full period");
        run(1);
        model_tick();
        check("R2 advance after DIV enables");

        // R3: seconds write coinciding with an advance drops it
        wr_on_tick(3'd0, 8'h30);
        m_sec = 30;
        check("R3 write beats advance");
        run(DIV - 1);
        check("R3 restart holds");
        run(1);
        model_tick();
        check("R3 advance after restart");

        // R11: minutes write meets a seconds carry
        m_sec = 59; m_min = 5; m_hr = 10;
        load();
        wr_on_tick(3'd1, 8'h20);
        m_sec = 0; m_min = 20;
        check("R11 write wins over carry");

        // R4/R5: 24-hour sweep across hour boundaries
        for (int h = 0; h < 24; h++) begin
            m_halt = 0; m_12 = 0; m_pm = 0; m_hr = h; m_min = 59; m_sec = 59;
            m_wday = (h % 7) + 1; m_date = 15; m_mon = 6; m_yr = 30;
            step_and_check("R5 R4 24h rollover");
        end

        // R6: 12-hour sweep, both halves of the day
        for (int p = 0; p < 2; p++) begin
            for (int h = 1; h <= 12; h++) begin
                m_12 = 1; m_pm = p; m_hr = h; m_min = 59; m_sec = 59;
                m_wday = 7; m_date = 10; m_mon = 3; m_yr = 11;
                step_and_check("R6 R7 12h rollover");
            end
        end

        // R8/R10: month ends for an ordinary, a leap and the last year
        for (int yi = 0; yi < 3; yi++) begin
            for (int m = 1; m <= 12; m++) begin
                for (int k = 1; k >= 0; k--) begin
                    m_12 = 0; m_pm = 0; m_hr = 23; m_min = 59; m_sec = 59;
                    m_yr = (yi == 0) ? 23 : (yi == 1) ? 24 : 99;
                    m_mon = m; m_date = mdays(m, m_yr) - k; m_wday = 7;
                    step_and_check("R8 R10 R7 month end");
                end
            end
        end

        // R9: February 28 for every year value
        for (int y = 0; y < 100; y++) begin
            m_12 = 0; m_pm = 0; m_hr = 23; m_min = 59; m_sec = 59;
            m_yr = y; m_mon = 2; m_date = 28; m_wday = 3;
            step_and_check("R9 leap february");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule